// File: doc/BRIEF.md
# Serial Write-Only Configuration Port

This block receives register writes over three wires: an active-low window enable, a serial clock and a serial data line. All three are brought into the core clock domain through synchronizers. Each rising serial clock edge seen while the window is open shifts one data bit into a frame register. When the window closes, the block commits the write, but only if at least 16 edges arrived in that window.

A frame has 16 bits. The first 5 bits must be zero. Next comes a 3-bit register address, most significant bit first. Last come 8 data bits, most significant bit first. Frames with a nonzero leading field, or with an address that has no register, are dropped.

The register file has four 8-bit registers, and the block drives the decoded configuration fields straight out. Register 0 bit 7 is a soft-release bit. While it is clear, every other register and every other bit of register 0 stays at its reset value. The block also drives a pad-direction signal that tells the shared data pins when to drive and when to listen.

Top module: `cfg_port`

## Requirements
- R1: While `rstN` is low, all registers take their reset values: register 0 = 00h, register 1 = 80h, register 2 = 00h, register 3 = 00h. After reset, `powerDown` = 1, `offsetCode` = 80h and every other field = 0.
- R2: Bits are captured on the rising edges of `cfgSclk` while `cfgEnN` is low. The frame is 5 zero bits, then address bits 2..0, then data bits 7..0, in that order. The write takes effect after `cfgEnN` rises.
- R3: A window with fewer than 16 rising serial clock edges changes no register.
- R4: A window with more than 16 rising edges writes using only the last 16 bits received.
- R5: A frame whose 5 leading bits are not all zero, or whose address is 4 to 7, changes no register.
- R6: While register 0 bit 7 is 0, writes to registers 1 to 3 have no effect, and those registers read as their reset values.
- R7: A write to register 0 while its bit 7 is 0 sets only bit 7 from the data. Bits 6..0 stay 0.
- R8: A write to register 0 with data bit 7 = 0, made while bit 7 is 1, returns every register to its reset value.
- R9: Register 0 decodes as follows:
  - bit 5 drives `driveDouble`
  - bit 4 drives `inputCds` (1 = correlated double sampling)
  - bits 3:2 drive `ftPos`
  - bit 1 drives `clkDouble`
  - bit 0 = 0 drives `powerDown` = 1
- R10: Register 1 drives `offsetCode`. Register 2 bits 5:0 drive `gainCode`. Register 3 decodes as follows:
  - bit 5 drives `shdDirect`
  - bits 4:3 drive `shdWidth`
  - bit 0 drives `orderSplit`
- R11: Writes are accepted while `powerDown` is 1.
- R12: `padDriveEn` is 0 while the window is open and 1 once it has closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| cfgEnN | input | 1 | Active-low write window enable |
| cfgSclk | input | 1 | Serial clock |
| cfgSdata | input | 1 | Serial data |
| padDriveEn | output | 1 | 1 = shared pins drive output data; 0 = pins listen |
| softRelease | output | 1 | Register 0 bit 7 |
| driveDouble | output | 1 | Strong output drive select |
| inputCds | output | 1 | Input mode: 0 = direct coupled, 1 = double sampling |
| ftPos | output | 2 | Feed-through sample position |
| clkDouble | output | 1 | Clock mode: 0 = single edge, 1 = both edges |
| powerDown | output | 1 | 1 while register 0 bit 0 is 0 |
| offsetCode | output | 8 | Black-level offset code |
| gainCode | output | 6 | Gain code |
| shdDirect | output | 1 | Data sample strobe taken directly from the pixel strobe |
| shdWidth | output | 2 | Data sample pulse width |
| orderSplit | output | 1 | Output order: split high and low bytes |

## Verification
The bench sends windows of 10 to 24 edges. A counter that does not saturate, or that checks for exactly 16, would then miss writes from long windows or accept truncated ones; a shifter that keeps the first bits rather than the last would write the leading junk. Directed frames cover the lock:
- writes to registers 1 to 3 while locked, which a design without the lock would accept;
- a full-data write to register 0 while locked, which would leak bits 6..0;
- clearing bit 7 while unlocked, which must reset everything else in the same commit.

Bad leading fields and unused addresses check that the decoder does not alias them onto real registers.

// File: rtl/cfg_port_pkg.sv
package cfg_port_pkg;

  localparam int CFG_ADDR_BITS  = 3;
  localparam int CFG_DATA_BITS  = 8;
  localparam int CFG_FRAME_BITS = 16;
  localparam int CFG_NUM_REGS   = 4;
  localparam int CFG_SYNC_STAGES = 2;

  // Strobes from control to datapath, one core-clock cycle each
  typedef struct packed {
    logic frameStart;  // window opened
    logic shiftEn;     // serial clock rose inside the window
    logic commit;      // window closed after a full frame
  } strobe_t;

  function automatic logic [CFG_DATA_BITS-1:0] regResetValue(input int idx);
    return (idx == 1) ? CFG_DATA_BITS'(8'h80) : '0;
  endfunction

endpackage

// File: rtl/cfg_port_ctrl.sv
module cfg_port_ctrl
  import cfg_port_pkg::*;
#(
  parameter int FRAME_BITS  = CFG_FRAME_BITS,
  parameter int SYNC_STAGES = CFG_SYNC_STAGES
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    enN,
  input  logic    sclk,
  output strobe_t strobe,
  output logic    enHigh
);

  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_BITS);

  logic [SYNC_STAGES-1:0] enSync;
  logic [SYNC_STAGES-1:0] sclkSync;
  logic enPrev;
  logic sclkPrev;
  logic enLvl;
  logic sclkLvl;
  logic [CNT_W-1:0] bitCount;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enSync   <= '1;
      sclkSync <= '0;
      enPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      enSync   <= {enSync[SYNC_STAGES-2:0], enN};
      sclkSync <= {sclkSync[SYNC_STAGES-2:0], sclk};
      enPrev   <= enLvl;
      sclkPrev <= sclkLvl;
    end
  end

  assign enLvl   = enSync[SYNC_STAGES-1];
  assign sclkLvl = sclkSync[SYNC_STAGES-1];
  assign enHigh  = enLvl;

  always_comb begin
    strobe.frameStart = enPrev & ~enLvl;
    strobe.shiftEn    = ~enLvl & sclkLvl & ~sclkPrev;
    strobe.commit     = ~enPrev & enLvl & (bitCount == CNT_FULL);
  end

  // Edge counter saturates at a full frame; extra edges keep it full
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCount <= '0;
    end else if (strobe.frameStart) begin
      bitCount <= strobe.shiftEn ? CNT_W'(1) : '0;
    end else if (strobe.shiftEn && bitCount != CNT_FULL) begin
      bitCount <= bitCount + CNT_W'(1);
    end
  end

endmodule

// File: rtl/cfg_port_dp.sv
module cfg_port_dp
  import cfg_port_pkg::*;
#(
  parameter int ADDR_BITS   = CFG_ADDR_BITS,
  parameter int DATA_BITS   = CFG_DATA_BITS,
  parameter int FRAME_BITS  = CFG_FRAME_BITS,
  parameter int NUM_REGS    = CFG_NUM_REGS,
  parameter int SYNC_STAGES = CFG_SYNC_STAGES
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          sdata,
  input  strobe_t                       strobe,
  output logic [NUM_REGS*DATA_BITS-1:0] regFlat
);

  localparam int PAD_BITS = FRAME_BITS - ADDR_BITS - DATA_BITS;
  localparam int LOCK_BIT = DATA_BITS - 1;

  logic [SYNC_STAGES-1:0] dSync;
  logic [FRAME_BITS-1:0]  shiftReg;
  logic [DATA_BITS-1:0]   frameData;
  logic [ADDR_BITS-1:0]   frameAddr;
  logic [PAD_BITS-1:0]    framePad;
  logic                   addrOk;
  logic                   wrEn;
  logic [DATA_BITS-1:0]   reg0Q;
  logic [DATA_BITS-1:0]   reg0Next;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dSync <= '0;
    else       dSync <= {dSync[SYNC_STAGES-2:0], sdata};
  end

  // Keeps the most recent FRAME_BITS bits of the window
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[FRAME_BITS-2:0], dSync[SYNC_STAGES-1]};
  end

  assign frameData = shiftReg[DATA_BITS-1:0];
  assign frameAddr = shiftReg[DATA_BITS +: ADDR_BITS];
  assign framePad  = shiftReg[FRAME_BITS-1 -: PAD_BITS];
  assign addrOk    = (int'(frameAddr) < NUM_REGS);
  assign wrEn      = strobe.commit && (framePad == '0) && addrOk;

  // Register 0: locked state admits only the release bit; clearing it wipes the rest
  always_comb begin
    reg0Next = reg0Q;
    if (wrEn && frameAddr == '0) begin
      if (!reg0Q[LOCK_BIT] || !frameData[LOCK_BIT])
        reg0Next = {frameData[LOCK_BIT], {(DATA_BITS-1){1'b0}}};
      else
        reg0Next = frameData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) reg0Q <= DATA_BITS'(regResetValue(0));
    else       reg0Q <= reg0Next;
  end

  assign regFlat[0 +: DATA_BITS] = reg0Q;

  for (genvar i = 1; i < NUM_REGS; i++) begin : g_reg
    logic [DATA_BITS-1:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                  q <= DATA_BITS'(regResetValue(i));
      else if (!reg0Next[LOCK_BIT])               q <= DATA_BITS'(regResetValue(i));
      else if (wrEn && frameAddr == ADDR_BITS'(i)) q <= frameData;
    end
    assign regFlat[i*DATA_BITS +: DATA_BITS] = q;
  end

endmodule

// File: rtl/cfg_port.sv
module cfg_port
  import cfg_port_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgEnN,
  input  logic       cfgSclk,
  input  logic       cfgSdata,
  output logic       padDriveEn,
  output logic       softRelease,
  output logic       driveDouble,
  output logic       inputCds,
  output logic [1:0] ftPos,
  output logic       clkDouble,
  output logic       powerDown,
  output logic [7:0] offsetCode,
  output logic [5:0] gainCode,
  output logic       shdDirect,
  output logic [1:0] shdWidth,
  output logic       orderSplit
);

  localparam int DW = CFG_DATA_BITS;

  strobe_t strobe;
  logic [CFG_NUM_REGS*DW-1:0] regFlat;
  logic [DW-1:0] r0, r1, r2, r3;

  cfg_port_ctrl i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enN    (cfgEnN),
    .sclk   (cfgSclk),
    .strobe (strobe),
    .enHigh (padDriveEn)
  );

  cfg_port_dp i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .sdata   (cfgSdata),
    .strobe  (strobe),
    .regFlat (regFlat)
  );

  assign r0 = regFlat[0*DW +: DW];
  assign r1 = regFlat[1*DW +: DW];
  assign r2 = regFlat[2*DW +: DW];
  assign r3 = regFlat[3*DW +: DW];

  assign softRelease = r0[7];
  assign driveDouble = r0[5];
  assign inputCds    = r0[4];
  assign ftPos       = r0[3:2];
  assign clkDouble   = r0[1];
  assign powerDown   = ~r0[0];
  assign offsetCode  = r1;
  assign gainCode    = r2[5:0];
  assign shdDirect   = r3[5];
  assign shdWidth    = r3[4:3];
  assign orderSplit  = r3[0];

endmodule

// File: rtl/cfg_port_chk.sv
module cfg_port_chk
  import cfg_port_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input strobe_t    strobe,
  input logic       padDriveEn,
  input logic       softRelease,
  input logic       powerDown,
  input logic       clkDouble,
  input logic [7:0] offsetCode,
  input logic [5:0] gainCode,
  input logic       shdDirect,
  input logic [1:0] shdWidth,
  input logic       orderSplit
);

  // R1: values seen as reset is released
  a_r1_reset_values: assert property (@(posedge clk)
    $rose(rstN) |-> (offsetCode == 8'h80 && gainCode == 6'd0 && powerDown && !softRelease));

  // R6: locked state shows defaults on every other field
  a_r6_locked_defaults: assert property (@(posedge clk) disable iff (!rstN)
    !softRelease |-> (offsetCode == 8'h80 && gainCode == 6'd0 && !shdDirect &&
                      shdWidth == 2'd0 && !orderSplit && powerDown && !clkDouble));

  // R2: configuration only moves in the cycle after a commit
  a_r2_hold_between_commits: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(offsetCode) && $stable(gainCode) && $stable(powerDown) &&
                        $stable(softRelease) && $stable(shdWidth)));

  // R2: a commit never coincides with shifting or window opening
  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.commit, strobe.shiftEn}) && $onehot0({strobe.commit, strobe.frameStart}));

  // R12: commit happens only with the pins released back to output
  a_r12_commit_with_drive: assert property (@(posedge clk) disable iff (!rstN)
    strobe.commit |-> padDriveEn);

endmodule

bind cfg_port cfg_port_chk i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .strobe      (strobe),
  .padDriveEn  (padDriveEn),
  .softRelease (softRelease),
  .powerDown   (powerDown),
  .clkDouble   (clkDouble),
  .offsetCode  (offsetCode),
  .gainCode    (gainCode),
  .shdDirect   (shdDirect),
  .shdWidth    (shdWidth),
  .orderSplit  (orderSplit)
);

// File: tb/test_cfg_port.sv
`timescale 1ns/1ps
module test_cfg_port;

  localparam int PH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgEnN = 1'b1;
  logic cfgSclk = 1'b0;
  logic cfgSdata = 1'b0;
  logic padDriveEn, softRelease, driveDouble, inputCds, clkDouble, powerDown;
  logic shdDirect, orderSplit;
  logic [1:0] ftPos, shdWidth;
  logic [7:0] offsetCode;
  logic [5:0] gainCode;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] mReg [4];

  always #10 clk = ~clk;

  cfg_port i_cfg_port (
    .clk(clk), .rstN(rstN), .cfgEnN(cfgEnN), .cfgSclk(cfgSclk), .cfgSdata(cfgSdata),
    .padDriveEn(padDriveEn), .softRelease(softRelease), .driveDouble(driveDouble),
    .inputCds(inputCds), .ftPos(ftPos), .clkDouble(clkDouble), .powerDown(powerDown),
    .offsetCode(offsetCode), .gainCode(gainCode), .shdDirect(shdDirect),
    .shdWidth(shdWidth), .orderSplit(orderSplit)
  );

  function automatic logic [24:0] expFields();
    return {mReg[0][7], mReg[0][5], mReg[0][4], mReg[0][3:2], mReg[0][1], ~mReg[0][0],
            mReg[1], mReg[2][5:0], mReg[3][5], mReg[3][4:3], mReg[3][0]};
  endfunction

  function automatic logic [24:0] actFields();
    return {softRelease, driveDouble, inputCds, ftPos, clkDouble, powerDown,
            offsetCode, gainCode, shdDirect, shdWidth, orderSplit};
  endfunction

  task automatic modelReset();
    mReg[0] = 8'h00; mReg[1] = 8'h80; mReg[2] = 8'h00; mReg[3] = 8'h00;
  endtask

  task automatic modelWrite(input logic [15:0] f);
    logic [2:0] a;
    logic [7:0] d;
    a = f[10:8];
    d = f[7:0];
    if (f[15:11] != 5'd0 || a > 3'd3) return;
    if (a == 3'd0) begin
      if (!mReg[0][7] || !d[7]) begin
        modelReset();
        mReg[0] = {d[7], 7'd0};
      end else begin
        mReg[0] = d;
      end
    end else if (mReg[0][7]) begin
      mReg[a] = d;
    end
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    check(tag, {7'd0, actFields()}, {7'd0, expFields()});
  endtask

  // Sends the low n bits of 'bits', highest first, in one window
  task automatic sendBits(input logic [31:0] bits, input int n, input bit chkPad);
    cfgEnN = 1'b0;
    waitCycles(PH);
    for (int i = n - 1; i >= 0; i--) begin
      cfgSdata = bits[i];
      waitCycles(PH);
      cfgSclk = 1'b1;
      waitCycles(PH);
      cfgSclk = 1'b0;
    end
    waitCycles(PH);
    if (chkPad) check("R12 pad released during window", {31'd0, padDriveEn}, 32'd0);
    cfgEnN = 1'b1;
    waitCycles(10);
    if (chkPad) check("R12 pad driving after window", {31'd0, padDriveEn}, 32'd1);
    if (n >= 16) modelWrite(bits[15:0]);
  endtask

  function automatic logic [15:0] mkFrame(input logic [2:0] a, input logic [7:0] d);
    return {5'd0, a, d};
  endfunction

  initial begin
    void'($urandom(32'h1234_5eed));
    modelReset();
    waitCycles(5);
    checkAll("R1 values during reset");
    rstN = 1'b1;
    waitCycles(3);
    checkAll("R1 values after reset");

    sendBits({16'd0, mkFrame(3'd1, 8'h3C)}, 16, 1);
    checkAll("R6 write reg1 while locked ignored");
    sendBits({16'd0, mkFrame(3'd0, 8'hFF)}, 16, 0);
    checkAll("R7 locked reg0 write sets bit7 only");
    check("R7 bit7 set", {31'd0, softRelease}, 32'd1);
    sendBits({16'd0, mkFrame(3'd0, 8'hA5)}, 16, 0);
    checkAll("R9 reg0 field decode");
    sendBits({16'd0, mkFrame(3'd0, 8'hDA)}, 16, 0);
    checkAll("R9 reg0 second pattern");
    sendBits({16'd0, mkFrame(3'd0, 8'h80)}, 16, 0);
    check("R11 powered down", {31'd0, powerDown}, 32'd1);
    sendBits({16'd0, mkFrame(3'd2, 8'hFF)}, 16, 0);
    checkAll("R11 gain write while powered down");
    sendBits({16'd0, mkFrame(3'd1, 8'h3C)}, 16, 0);
    sendBits({16'd0, mkFrame(3'd3, 8'h39)}, 16, 0);
    checkAll("R10 reg1 reg2 reg3 decode");
    sendBits({16'd0, mkFrame(3'd1, 8'h11)}, 15, 0);
    checkAll("R3 15-edge window no write");
    sendBits({16'd0, mkFrame(3'd1, 8'h11)}, 10, 0);
    checkAll("R3 10-edge window no write");
    sendBits({12'd0, 4'hF, mkFrame(3'd1, 8'h22)}, 20, 0);
    checkAll("R4 20-edge window uses last 16");
    check("R4 offset value", {24'd0, offsetCode}, 32'h22);
    sendBits({16'd0, 16'h0844}, 16, 0);
    checkAll("R5 nonzero leading field ignored");
    sendBits({16'd0, mkFrame(3'd5, 8'h44)}, 16, 0);
    checkAll("R5 address 5 ignored");
    sendBits({16'd0, mkFrame(3'd0, 8'h05)}, 16, 0);
    checkAll("R8 clearing release bit restores defaults");
    check("R8 offset default", {24'd0, offsetCode}, 32'h80);
    sendBits({16'd0, mkFrame(3'd0, 8'h81)}, 16, 0);
    checkAll("R2 unlock again");

    for (int k = 0; k < 150; k++) begin
      logic [2:0] a;
      logic [7:0] d;
      logic [15:0] f;
      logic [31:0] bits;
      int n;
      int sel;
      a = 3'($urandom_range(0, 4));
      d = 8'($urandom);
      if (a == 3'd0 && $urandom_range(0, 9) < 8) d[7] = 1'b1;
      f = mkFrame(a, d);
      if ($urandom_range(0, 9) == 0) f[15:11] = 5'($urandom_range(1, 31));
      sel = $urandom_range(0, 19);
      n = (sel < 14) ? 16 : (sel < 17) ? $urandom_range(17, 24) : $urandom_range(10, 15);
      bits = {$urandom, f} >> 0;
      bits = {16'($urandom), f};
      sendBits(bits, n, (k % 25) == 0);
      checkAll("R9/R10 random frame");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule